// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter

This block is the processor-facing end of an interrupt controller. Upstream routing logic offers it a source index, one source per cycle, and the presenter decides whether that source may interrupt its processor. It keeps two sets of source bits: sources delivered but not yet taken (raised) and sources the processor has taken but not yet finished (in service). A 4-bit task priority gates deliveries. The interrupt line rises only when a new source outranks the best raised entry and the best in-service entry.

The processor works through a small register window. Reading the acknowledge register lowers the line. The read returns the vector of the best raised source, which then moves into service. If nothing valid is left, the read returns a programmable spurious vector. Writing the end-of-interrupt register retires the best in-service source. If a raised source is still waiting and is now the highest, the line rises again. Each source carries a priority, a vector and an edge/level flag. The presenter also keeps each source's activity bit and tells the sensing logic when an edge source's pending state must be cleared.

Top module: `pic_presenter`

## Requirements
- R1: The task priority resets to 0xF. A delivery is accepted only when the source priority is strictly greater than the task priority. A refused delivery leaves the raised set, the activity bits and irq_o unchanged.
- R2: An accepted delivery adds the source to the raised set and sets its activity bit (act_o). A delivery of a source that is already raised is dropped, so one acknowledge consumes it.
- R3: On an accepted delivery, irq_o goes high on the next cycle. This does not happen if the new priority is below the best raised priority, or below the best in-service priority. Equal priority does not hide the delivery.
- R4: The best entry of a set is the one with the highest priority. Among equal priorities the lowest source index wins. This applies both to acknowledge and to end-of-interrupt.
- R5: An acknowledge read (bus_addr_i = 1) lowers irq_o on the next cycle. With an empty raised set it returns the spurious vector, which resets to 0xFF.
- R6: On acknowledge, the best raised source is re-validated. If its activity bit is clear, or its priority is no longer above the task priority, its activity is cleared and the spurious vector is returned. Otherwise its vector is returned and it enters the in-service set.
- R7: Acknowledge always removes the chosen source from the raised set. For an edge source (src_edge_i bit = 1) it also clears activity and pulses that source's bit of pend_clr_o in the read cycle. pend_clr_o is never multi-hot.
- R8: An end-of-interrupt write (bus_addr_i = 2) removes the best in-service source. irq_o rises again if a raised source remains and either nothing stays in service or that raised priority exceeds every remaining in-service priority.
- R9: An end-of-interrupt write with an empty in-service set changes nothing.
- R10: Register window: address 0 holds the task priority in bits 3:0, address 1 is acknowledge, address 2 is end-of-interrupt, and address 3 holds the spurious vector in bits 7:0. Read data is valid in the read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dlv_valid_i | input | 1 | Delivery offer this cycle |
| dlv_src_i | input | IDX_W | Index of the offered source |
| src_prio_i | input | N*PRIO_W | Priority of every source |
| src_vec_i | input | N*VEC_W | Vector of every source |
| src_edge_i | input | N | 1 = edge-sensed source |
| act_clr_i | input | N | Clear activity (level source dropped) |
| bus_re_i | input | 1 | Register read strobe |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register select |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, same cycle |
| irq_o | output | 1 | Interrupt to the processor |
| act_o | output | N | Per-source activity bits |
| pend_clr_o | output | N | Pending clear pulse for edge sources |

## Verification
The hardest case to reach is the end-of-interrupt re-raise where the in-service set is not emptied. It needs two in-service sources of different priority and a raised source whose priority lies between them. That raised source must also have been hidden when it was delivered, so irq_o is low beforehand. The stimulus drops the task priority to zero and acknowledges a very low and a very high source. It then delivers a mid-priority source, which the high in-service entry hides. The next end-of-interrupt retires only the high one, and irq_o must rise. Ties of equal priority, in both the raised and the in-service sets, are set up by delivering the higher index first.

// File: rtl/pic_pres_pkg.sv
package pic_pres_pkg;
  typedef enum logic [1:0] {
    REG_TPR = 2'd0,
    REG_ACK = 2'd1,
    REG_EOI = 2'd2,
    REG_SPV = 2'd3
  } reg_sel_e;

  localparam int TPR_W = 4;
  localparam logic [TPR_W-1:0] TPR_RST = '1;
endpackage

// File: rtl/pic_pres_pick.sv
// Highest-priority member of a set; strict compare keeps the lowest index on ties.
module pic_pres_pick #(
  parameter int N = 8,
  parameter int PRIO_W = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]        set_i,
  input  logic [N*PRIO_W-1:0] prio_i,
  output logic                valid_o,
  output logic [IDX_W-1:0]    idx_o,
  output logic [PRIO_W-1:0]   prio_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    prio_o  = '0;
    for (int i = 0; i < N; i++) begin
      if (set_i[i] && (!valid_o || prio_i[i*PRIO_W +: PRIO_W] > prio_o)) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
        prio_o  = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/pic_pres_regs.sv
module pic_pres_regs
  import pic_pres_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_re_i,
  input  logic              bus_we_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic [VEC_W-1:0]  ack_data_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [TPR_W-1:0]  tpr_o,
  output logic [VEC_W-1:0]  spv_o,
  output logic              ack_rd_o,
  output logic              eoi_wr_o
);
  reg_sel_e sel;
  logic unused_wdata;

  assign sel          = reg_sel_e'(bus_addr_i);
  assign ack_rd_o     = bus_re_i && (sel == REG_ACK);
  assign eoi_wr_o     = bus_we_i && (sel == REG_EOI);
  assign unused_wdata = ^bus_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tpr_o <= TPR_RST;
      spv_o <= '1;
    end else if (bus_we_i) begin
      if (sel == REG_TPR) tpr_o <= bus_wdata_i[TPR_W-1:0];
      if (sel == REG_SPV) spv_o <= bus_wdata_i[VEC_W-1:0];
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_re_i) begin
      unique case (sel)
        REG_TPR: bus_rdata_o = DATA_W'(tpr_o);
        REG_ACK: bus_rdata_o = DATA_W'(ack_data_i);
        REG_SPV: bus_rdata_o = DATA_W'(spv_o);
        default: bus_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/pic_presenter.sv
module pic_presenter
  import pic_pres_pkg::*;
#(
  parameter int N = 8,
  parameter int PRIO_W = 4,
  parameter int VEC_W = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                dlv_valid_i,
  input  logic [IDX_W-1:0]    dlv_src_i,
  input  logic [N*PRIO_W-1:0] src_prio_i,
  input  logic [N*VEC_W-1:0]  src_vec_i,
  input  logic [N-1:0]        src_edge_i,
  input  logic [N-1:0]        act_clr_i,
  input  logic                bus_re_i,
  input  logic                bus_we_i,
  input  logic [1:0]          bus_addr_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  output logic                irq_o,
  output logic [N-1:0]        act_o,
  output logic [N-1:0]        pend_clr_o
);
  localparam int CMP_W = (PRIO_W > TPR_W) ? PRIO_W : TPR_W;

  logic [N-1:0]      raised_q, svc_q, act_q;
  logic [N-1:0]      raised_d, svc_d, act_d;
  logic              irq_q, irq_d;
  logic [PRIO_W-1:0] prio [N];
  logic [VEC_W-1:0]  vec  [N];

  logic              rv, sv;
  logic [IDX_W-1:0]  ridx, sidx;
  logic [PRIO_W-1:0] rprio, sprio;

  logic [TPR_W-1:0]  tpr;
  logic [VEC_W-1:0]  spv, ack_vec;
  logic              ack, eoi;

  logic [PRIO_W-1:0] dprio;
  logic              accept, show, ack_ok, reraise, above_rest;

  for (genvar g = 0; g < N; g++) begin : g_unpack
    assign prio[g] = src_prio_i[g*PRIO_W +: PRIO_W];
    assign vec[g]  = src_vec_i[g*VEC_W +: VEC_W];
  end

  pic_pres_pick #(.N(N), .PRIO_W(PRIO_W)) u_pick_raised (
    .set_i  (raised_q),
    .prio_i (src_prio_i),
    .valid_o(rv),
    .idx_o  (ridx),
    .prio_o (rprio)
  );

  pic_pres_pick #(.N(N), .PRIO_W(PRIO_W)) u_pick_svc (
    .set_i  (svc_q),
    .prio_i (src_prio_i),
    .valid_o(sv),
    .idx_o  (sidx),
    .prio_o (sprio)
  );

  pic_pres_regs #(.VEC_W(VEC_W), .DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_re_i   (bus_re_i),
    .bus_we_i   (bus_we_i),
    .bus_addr_i (bus_addr_i),
    .bus_wdata_i(bus_wdata_i),
    .ack_data_i (ack_vec),
    .bus_rdata_o(bus_rdata_o),
    .tpr_o      (tpr),
    .spv_o      (spv),
    .ack_rd_o   (ack),
    .eoi_wr_o   (eoi)
  );

  // delivery acceptance and line decision against current set state
  assign dprio  = prio[dlv_src_i];
  assign accept = dlv_valid_i && (CMP_W'(dprio) > CMP_W'(tpr)) && !raised_q[dlv_src_i];
  assign show   = accept && !(rv && (dprio < rprio)) && !(sv && (dprio < sprio));

  // acknowledge re-validation
  assign ack_ok  = rv && act_q[ridx] && (CMP_W'(rprio) > CMP_W'(tpr));
  assign ack_vec = ack_ok ? vec[ridx] : spv;

  always_comb begin
    pend_clr_o = '0;
    if (ack && rv && src_edge_i[ridx]) pend_clr_o[ridx] = 1'b1;
  end

  // raised top must exceed every in-service entry that survives the EOI
  always_comb begin
    above_rest = 1'b1;
    for (int i = 0; i < N; i++) begin
      if (svc_q[i] && (IDX_W'(i) != sidx) && !(rprio > prio[i])) above_rest = 1'b0;
    end
  end
  assign reraise = eoi && sv && rv && above_rest;

  always_comb begin
    raised_d = raised_q;
    svc_d    = svc_q;
    act_d    = act_q & ~act_clr_i;
    irq_d    = irq_q;
    if (ack) begin
      irq_d = 1'b0;
      if (rv) begin
        raised_d[ridx] = 1'b0;
        if (ack_ok) svc_d[ridx] = 1'b1;
        if (!ack_ok || src_edge_i[ridx]) act_d[ridx] = 1'b0;
      end
    end
    if (eoi && sv) svc_d[sidx] = 1'b0;
    if (accept) begin
      raised_d[dlv_src_i] = 1'b1;
      act_d[dlv_src_i]    = 1'b1;
    end
    if (show || reraise) irq_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raised_q <= '0;
      svc_q    <= '0;
      act_q    <= '0;
      irq_q    <= 1'b0;
    end else begin
      raised_q <= raised_d;
      svc_q    <= svc_d;
      act_q    <= act_d;
      irq_q    <= irq_d;
    end
  end

  assign irq_o = irq_q;
  assign act_o = act_q;
endmodule

// File: rtl/pic_presenter_chk.sv
module pic_presenter_chk #(
  parameter int N = 8,
  parameter int PRIO_W = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                dlv_valid_i,
  input logic [IDX_W-1:0]    dlv_src_i,
  input logic [N*PRIO_W-1:0] src_prio_i,
  input logic [N-1:0]        act_clr_i,
  input logic                bus_re_i,
  input logic                bus_we_i,
  input logic [1:0]          bus_addr_i,
  input logic                irq_o,
  input logic [N-1:0]        act_o,
  input logic [N-1:0]        pend_clr_o,
  input logic [N-1:0]        raised_q,
  input logic [N-1:0]        svc_q,
  input logic [3:0]          tpr,
  input logic                rv,
  input logic [IDX_W-1:0]    ridx,
  input logic                sv
);
  logic [PRIO_W-1:0] dprio;
  logic ack_c, eoi_c, hi;
  assign dprio = src_prio_i[dlv_src_i*PRIO_W +: PRIO_W];
  assign ack_c = bus_re_i && (bus_addr_i == 2'd1);
  assign eoi_c = bus_we_i && (bus_addr_i == 2'd2);
  assign hi    = (32'(dprio) > 32'(tpr));

  AST_LOW_PRIO_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlv_valid_i && !hi && !ack_c |=> raised_q == $past(raised_q)) else $error("R1"); // R1

  AST_ACCEPT_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlv_valid_i && hi && !ack_c && (act_clr_i == '0) |=> raised_q[$past(dlv_src_i)] && act_o[$past(dlv_src_i)]) else $error("R2"); // R2

  AST_ACK_LOWERS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_c && !dlv_valid_i && !bus_we_i |=> !irq_o) else $error("R5"); // R5

  AST_SVC_ONLY_BY_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_c |=> (svc_q & ~$past(svc_q)) == '0) else $error("R6"); // R6

  AST_ACK_POPS_RAISED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_c && rv && !dlv_valid_i |=> !raised_q[$past(ridx)]) else $error("R7"); // R7

  AST_PEND_CLR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pend_clr_o)) else $error("R7"); // R7

  AST_EOI_EMPTY_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_c && !sv && !ack_c && !dlv_valid_i |=> $stable(svc_q) && $stable(irq_o)) else $error("R9"); // R9
endmodule

bind pic_presenter pic_presenter_chk #(.N(N), .PRIO_W(PRIO_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dlv_valid_i(dlv_valid_i),
  .dlv_src_i  (dlv_src_i),
  .src_prio_i (src_prio_i),
  .act_clr_i  (act_clr_i),
  .bus_re_i   (bus_re_i),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .irq_o      (irq_o),
  .act_o      (act_o),
  .pend_clr_o (pend_clr_o),
  .raised_q   (raised_q),
  .svc_q      (svc_q),
  .tpr        (tpr),
  .rv         (rv),
  .ridx       (ridx),
  .sv         (sv)
);

// File: tb/test_pic_presenter.sv
module test_pic_presenter;
  localparam int N = 8;
  localparam int PW = 4;
  localparam int VW = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dlv_valid = 1'b0;
  logic [2:0] dlv_src = '0;
  logic [N*PW-1:0] src_prio;
  logic [N*VW-1:0] src_vec;
  logic [N-1:0] src_edge;
  logic [N-1:0] act_clr = '0;
  logic bus_re = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic irq;
  logic [N-1:0] act, pend_clr;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] vec;
    logic [7:0] pend;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  pic_presenter #(.N(N), .PRIO_W(PW), .VEC_W(VW), .DATA_W(DW)) i_pic_presenter (
    .clk_i(clk), .rst_ni(rst_n), .dlv_valid_i(dlv_valid), .dlv_src_i(dlv_src),
    .src_prio_i(src_prio), .src_vec_i(src_vec), .src_edge_i(src_edge), .act_clr_i(act_clr),
    .bus_re_i(bus_re), .bus_we_i(bus_we), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .irq_o(irq), .act_o(act), .pend_clr_o(pend_clr)
  );

  task automatic chk(string tag, logic [31:0] actual, logic [31:0] expected);
    n_chk++;
    if (actual !== expected) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, actual, expected);
    end
  endtask

  task automatic deliver(int idx);
    @(negedge clk);
    dlv_valid = 1'b1;
    dlv_src = 3'(idx);
    @(negedge clk);
    dlv_valid = 1'b0;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [31:0] expected, string tag);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    #5 chk(tag, bus_rdata, expected);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  // driver: queue the expected acknowledge result, monitor compares it
  task automatic ack(logic [7:0] v, logic [7:0] p, string tag);
    exp_t e;
    e.vec = v; e.pend = p; e.tag = tag;
    @(negedge clk);
    exp_q.push_back(e);
    bus_re = 1'b1; bus_addr = 2'd1;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic eoi();
    wr(2'd2, 32'h0);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #5;
      if (bus_re && bus_addr == 2'd1) begin
        if (exp_q.size() == 0) begin
          chk("R5 unexpected acknowledge", 32'h1, 32'h0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk({e.tag, " vector"}, bus_rdata, {24'h0, e.vec});
          chk({e.tag, " pend_clr"}, {24'h0, pend_clr}, {24'h0, e.pend});
        end
      end
    end
  end

  initial begin : watchdog
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : stim
    // priorities 3,5,5,7,2,9,1,4; vectors 0x40+i; sources 0..3 edge
    src_prio = {4'd4, 4'd1, 4'd9, 4'd2, 4'd7, 4'd5, 4'd5, 4'd3};
    for (int i = 0; i < N; i++) src_vec[i*VW +: VW] = 8'h40 + 8'(i);
    src_edge = 8'b0000_1111;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    chk("R1 irq after reset", {31'h0, irq}, 32'h0);
    chk("R2 act after reset", {24'h0, act}, 32'h0);
    rd(2'd0, 32'hF, "R1 task priority reset");
    rd(2'd3, 32'hFF, "R5 spurious reset");
    ack(8'hFF, 8'h00, "R5 ack empty");

    deliver(5);
    chk("R1 refused at tpr F irq", {31'h0, irq}, 32'h0);
    chk("R1 refused at tpr F act", {24'h0, act}, 32'h0);
    wr(2'd0, 32'd2);
    deliver(4);
    deliver(6);
    chk("R1 equal/lower refused irq", {31'h0, irq}, 32'h0);
    chk("R1 equal/lower refused act", {24'h0, act}, 32'h0);

    deliver(1);
    chk("R3 delivery raises irq", {31'h0, irq}, 32'h1);
    chk("R2 activity set", {24'h0, act}, 32'h02);
    ack(8'h41, 8'h02, "R7 ack edge source");
    chk("R5 ack lowers irq", {31'h0, irq}, 32'h0);
    chk("R7 edge activity cleared", {24'h0, act}, 32'h00);
    deliver(2);
    chk("R3 equal to in-service raises", {31'h0, irq}, 32'h1);
    ack(8'h42, 8'h04, "R6 ack valid source");
    deliver(7);
    chk("R3 hidden by in-service", {31'h0, irq}, 32'h0);
    chk("R2 level activity set", {24'h0, act}, 32'h80);
    deliver(7);
    deliver(5);
    chk("R3 high delivery raises", {31'h0, irq}, 32'h1);
    deliver(3);
    ack(8'h45, 8'h00, "R4 top raised first");
    chk("R5 irq low after ack", {31'h0, irq}, 32'h0);
    ack(8'h43, 8'h08, "R4 next raised");
    ack(8'h47, 8'h00, "R6 level source");
    ack(8'hFF, 8'h00, "R2 repeated delivery dropped");
    repeat (5) eoi();
    chk("R8 no reraise with empty raised", {31'h0, irq}, 32'h0);
    eoi();
    chk("R9 empty eoi irq", {31'h0, irq}, 32'h0);
    chk("R9 empty eoi activity", {24'h0, act}, 32'hA0);
    deliver(7);
    chk("R9 in-service set left empty", {31'h0, irq}, 32'h1);
    ack(8'h47, 8'h00, "R9 ack after empty eoi");
    eoi();

    // ties
    deliver(2);
    deliver(1);
    chk("R3 equal to raised raises", {31'h0, irq}, 32'h1);
    ack(8'h41, 8'h02, "R4 tie lowest index");
    ack(8'h42, 8'h04, "R4 tie second");
    deliver(7);
    chk("R3 hidden by in-service tie pair", {31'h0, irq}, 32'h0);
    eoi();
    chk("R8 no reraise below remaining", {31'h0, irq}, 32'h0);
    eoi();
    chk("R8 reraise when service empties", {31'h0, irq}, 32'h1);
    ack(8'h47, 8'h00, "R8 ack after reraise");
    eoi();

    // re-raise above the remaining in-service entry
    wr(2'd0, 32'd0);
    deliver(6);
    ack(8'h46, 8'h00, "R6 low source acked");
    deliver(5);
    ack(8'h45, 8'h00, "R6 high source acked");
    deliver(1);
    chk("R3 hidden by high in-service", {31'h0, irq}, 32'h0);
    eoi();
    chk("R8 reraise above remaining", {31'h0, irq}, 32'h1);
    ack(8'h41, 8'h02, "R8 raised source taken");
    eoi();
    eoi();

    // activity dropped before acknowledge
    deliver(4);
    chk("R2 act src4", {31'h0, act[4]}, 32'h1);
    @(negedge clk); act_clr = 8'h10;
    @(negedge clk); act_clr = 8'h00;
    chk("R6 activity cleared by source", {31'h0, act[4]}, 32'h0);
    ack(8'hFF, 8'h00, "R6 spurious inactive");
    ack(8'hFF, 8'h00, "R7 spurious source removed");

    // task priority raised before acknowledge
    deliver(7);
    chk("R3 raise before tpr change", {31'h0, irq}, 32'h1);
    wr(2'd0, 32'd6);
    ack(8'hFF, 8'h00, "R6 spurious tpr");
    chk("R6 spurious clears activity", {31'h0, act[7]}, 32'h0);

    wr(2'd3, 32'h1A3);
    rd(2'd3, 32'hA3, "R10 spurious field");
    ack(8'hA3, 8'h00, "R5 programmed spurious");
    wr(2'd0, 32'hFFFF_FFF3);
    rd(2'd0, 32'h3, "R10 task priority field");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule